// File: doc/BRIEF.md
# USB Device Event Flags with Transaction-Status Queue

This block sits between the packet engine of a USB device controller and the processor's register bus. The engine reports what happened on the bus as one-cycle pulses: stall sent, resume seen, idle-bus sleep, start-of-frame token, error, bus reset. Each pulse lands in a sticky flag. Software reads the flags, masks them through an enable register and clears them by writing ones. All enabled flags are ORed into one interrupt line.

Completed transactions arrive separately, as a push strobe with a status word that names the endpoint and the buffer descriptor. The first word waiting goes into a visible status register and raises the transaction-done flag. A second word that arrives while the first still waits is parked in a one-entry holding slot. When software acknowledges the transaction-done flag, the parked word moves into the visible register and the flag comes back on the next cycle. If no word is parked, the visible register empties. A push that finds both slots full is dropped and recorded in a sticky overflow bit.

Software uses the block through a small synchronous write port and a combinational read port. There are four addresses: 0 is the flags, 1 is the enables, 2 is the transaction status word and 3 is the overflow bit.

Top module: `usbd_evt_status`

## Requirements
- R1: After a synchronous active-low reset, all four addresses read 0x00 and the interrupt line is low.
- R2: A pulse on `evt_pulse` bit 7 (stall), 5 (resume), 4 (sleep), 2 (start-of-frame), 1 (error) or 0 (bus reset) sets the same bit of the flags byte at address 0, and the flag reads back one cycle after the pulse. Pulses on event bits 6 and 3 are ignored, and flag bit 6 always reads 0.
- R3: Writing address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: If a flag's event pulse and its write-1 clear occur in the same cycle, the flag stays set.
- R5: Address 1 holds an enable mask with the same bit layout as the flags byte, and its bit 6 always reads 0. `irq_o` is high exactly when some flag and its enable bit are both 1.
- R6: A `tok_push` while no status word is waiting loads `tok_word` into address 2 and sets flag bit 3. Both are visible the next cycle.
- R7: A push while a word is already waiting is parked. Writing 1 to flag bit 3 while that flag is set moves the parked word into address 2 and reads bit 3 as 0 for one cycle. Bit 3 reads 1 again on the following cycle.
- R8: Acknowledging bit 3 with nothing parked clears bit 3, and address 2 reads 0x00.
- R9: A push that arrives while both a visible word and a parked word exist is dropped, and it sets the overflow bit, read as bit 0 of address 3. Writing 1 to that bit clears it.
- R10: Writing 1 to flag bit 3 while bit 3 reads 0 has no effect on the status words.
- R11: If a push and an acknowledge occur in the same cycle and nothing is parked, the pushed word becomes visible and bit 3 stays set. If a word is parked, the parked word becomes visible and the pushed word takes the holding slot without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data for `reg_addr` |
| evt_pulse | input | 8 | One-cycle event pulses, one per flag bit |
| tok_push | input | 1 | A transaction finished; `tok_word` is valid |
| tok_word | input | STAT_W | Endpoint and descriptor status of the finished transaction |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- a pulsed flag is set on the next cycle;
- a set flag stays set unless a write clears it;
- a word is never parked while the visible register is empty;
- the transaction-done flag implies a visible word;
- the flag returns one cycle after a promotion;
- a push into a full queue raises overflow;
- an acknowledge while the flag is low leaves the visible word alone.

Other behaviour shows only in the bench's sequences, because it depends on what happened several operations earlier:
- which word becomes visible after a promotion;
- the same-cycle push-and-acknowledge cases;
- reserved bits reading zero;
- the event-beats-clear race;
- the interrupt following the enable mask.

// File: rtl/usbd_evt_pkg.sv
// Package: shared constants for the USB device event/status register block.
// Assumes an 8-bit flags byte whose bit positions are fixed by software.
package usbd_evt_pkg;
    localparam int FLAG_W     = 8;
    localparam int BIT_STALL  = 7;
    localparam int BIT_RSVD   = 6;
    localparam int BIT_RESUME = 5;
    localparam int BIT_SLEEP  = 4;
    localparam int BIT_TOKDN  = 3;
    localparam int BIT_SOF    = 2;
    localparam int BIT_ERR    = 1;
    localparam int BIT_BUSRST = 0;

    // Bits that are real flags (everything except the reserved bit)
    localparam logic [FLAG_W-1:0] FLAG_LIVE =
        ~(FLAG_W'(1) << BIT_RSVD);
    // Bits driven directly by event pulses (token bit comes from the queue)
    localparam logic [FLAG_W-1:0] EVT_LIVE =
        FLAG_LIVE & ~(FLAG_W'(1) << BIT_TOKDN);

    // Register map
    localparam int ADR_FLAGS = 0;
    localparam int ADR_EN    = 1;
    localparam int ADR_TOKW  = 2;
    localparam int ADR_OVF   = 3;
endpackage

// File: rtl/usbd_flag_bank.sv
// Module: usbd_flag_bank
// A bank of sticky flags, one per bit of MASK. A set pulse sets the flag and
// a clear bit clears it; a set in the same cycle as a clear wins. Bits not in
// MASK are tied to zero. Assumes set and clear are single-cycle strobes.
module usbd_flag_bank #(
    parameter int              W    = 8,
    parameter logic [W-1:0]    MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    wire [W-1:0] flag_w;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic bit_q;
            // Sticky bit: set dominates clear
            always_ff @(posedge clk) begin
                if (!rst_n)        bit_q <= 1'b0;
                else if (set_i[i]) bit_q <= 1'b1;
                else if (clr_i[i]) bit_q <= 1'b0;
            end
            assign flag_w[i] = bit_q;
        end else begin : g_tied
            assign flag_w[i] = 1'b0;
        end
    end

    assign flag_o = flag_w;

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & MASK) != '0) |=> ((flag_w & $past(set_i & MASK)) == $past(set_i & MASK)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_w != '0) |=> ((flag_w & $past(flag_w & ~clr_i)) == $past(flag_w & ~clr_i)));
endmodule

// File: rtl/usbd_tok_queue.sv
// Module: usbd_tok_queue
// Two-slot store for transaction status words: a visible slot and a one-deep
// holding slot. Owns the transaction-done flag and the sticky overflow bit.
// Assumes ack_req is a raw write-1 strobe; it is honoured only while the flag
// is set. After a promotion from the holding slot the flag is low for one
// cycle and returns on the next.
module usbd_tok_queue #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [STAT_W-1:0] word_i,
    input  logic              ack_req_i,
    input  logic              ovf_clr_i,
    output logic              flag_o,
    output logic [STAT_W-1:0] vis_o,
    output logic              ovf_o
);
    logic [STAT_W-1:0] vis_q, hold_q, vis_n, hold_n;
    logic              vis_v_q, hold_v_q, vis_v_n, hold_v_n;
    logic              flag_q, flag_n, rearm_q, rearm_n, ovf_q;
    logic              ack, drop;

    assign ack = ack_req_i & flag_q;

    // Next-state for both slots, the flag and the re-arm marker
    always_comb begin
        vis_n    = vis_q;
        hold_n   = hold_q;
        vis_v_n  = vis_v_q;
        hold_v_n = hold_v_q;
        flag_n   = flag_q;
        rearm_n  = 1'b0;
        drop     = 1'b0;
        if (rearm_q) flag_n = 1'b1;
        if (ack) begin
            flag_n = 1'b0;
            if (hold_v_q) begin
                vis_n    = hold_q;
                hold_v_n = 1'b0;
                hold_n   = '0;
                rearm_n  = 1'b1;
            end else begin
                vis_n   = '0;
                vis_v_n = 1'b0;
            end
        end
        if (push_i) begin
            if (!vis_v_n) begin
                vis_n   = word_i;
                vis_v_n = 1'b1;
                flag_n  = 1'b1;
            end else if (!hold_v_n) begin
                hold_n   = word_i;
                hold_v_n = 1'b1;
            end else begin
                drop = 1'b1;
            end
        end
    end

    // Slot and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q    <= '0;
            hold_q   <= '0;
            vis_v_q  <= 1'b0;
            hold_v_q <= 1'b0;
            flag_q   <= 1'b0;
            rearm_q  <= 1'b0;
        end else begin
            vis_q    <= vis_n;
            hold_q   <= hold_n;
            vis_v_q  <= vis_v_n;
            hold_v_q <= hold_v_n;
            flag_q   <= flag_n;
            rearm_q  <= rearm_n;
        end
    end

    // Sticky overflow: a drop wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (drop)      ovf_q <= 1'b1;
        else if (ovf_clr_i) ovf_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign vis_o  = vis_q;
    assign ovf_o  = ovf_q;

    // R7
    hold_needs_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v_q |-> vis_v_q);

    // R6
    flag_needs_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> vis_v_q);

    // R7
    rearm_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_q |=> flag_q);

    // R9
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && vis_v_q && hold_v_q && !ack) |=> ovf_q);

    // R8
    ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hold_v_q && !push_i) |=> (!vis_v_q && !flag_q && vis_q == '0));
endmodule

// File: rtl/usbd_evt_status.sv
// Module: usbd_evt_status (top)
// Event flags, enable mask, transaction-status queue and combined interrupt
// for a USB device controller. Register map: 0 flags (write 1 to clear),
// 1 enables, 2 visible transaction status word, 3 overflow (bit 0, write 1
// to clear). Assumes REG_W >= 8 and STAT_W <= REG_W; reads are combinational.
module usbd_evt_status
    import usbd_evt_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int REG_W  = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [7:0]        evt_pulse,
    input  logic              tok_push,
    input  logic [STAT_W-1:0] tok_word,
    output logic              irq_o
);
    localparam logic [FLAG_W-1:0] TOK_BIT = FLAG_W'(1) << BIT_TOKDN;

    logic              wr_flags, wr_en_reg, wr_ovf;
    logic [FLAG_W-1:0] clr_vec, evt_flags, flag_byte, en_q;
    logic              tok_flag, ovf;
    logic [STAT_W-1:0] vis_word;

    assign wr_flags  = reg_wr_en && (reg_addr == ADDR_W'(ADR_FLAGS));
    assign wr_en_reg = reg_wr_en && (reg_addr == ADDR_W'(ADR_EN));
    assign wr_ovf    = reg_wr_en && (reg_addr == ADDR_W'(ADR_OVF));
    assign clr_vec   = wr_flags ? reg_wdata[FLAG_W-1:0] : '0;

    usbd_flag_bank #(
        .W    (FLAG_W),
        .MASK (EVT_LIVE)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_pulse),
        .clr_i  (clr_vec),
        .flag_o (evt_flags)
    );

    usbd_tok_queue #(
        .STAT_W (STAT_W)
    ) u_tokq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (tok_push),
        .word_i    (tok_word),
        .ack_req_i (clr_vec[BIT_TOKDN]),
        .ovf_clr_i (wr_ovf && reg_wdata[0]),
        .flag_o    (tok_flag),
        .vis_o     (vis_word),
        .ovf_o     (ovf)
    );

    // Enable mask register; reserved bit held at zero
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_en_reg) en_q <= reg_wdata[FLAG_W-1:0] & FLAG_LIVE;
    end

    assign flag_byte = evt_flags | (tok_flag ? TOK_BIT : '0);
    assign irq_o     = |(flag_byte & en_q);

    // Read multiplexer over the four registers
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADR_FLAGS): reg_rdata = REG_W'(flag_byte);
            ADDR_W'(ADR_EN):    reg_rdata = REG_W'(en_q);
            ADDR_W'(ADR_TOKW):  reg_rdata = REG_W'(vis_word);
            ADDR_W'(ADR_OVF):   reg_rdata = REG_W'(ovf);
            default:            reg_rdata = '0;
        endcase
    end

    // R10
    stale_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[BIT_TOKDN] && !tok_flag && !tok_push) |=> $stable(vis_word));

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);
endmodule

// File: tb/test_usbd_evt_status.sv
`timescale 1ns/1ps
module test_usbd_evt_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] evt_pulse = 8'h00;
    logic       tok_push = 1'b0;
    logic [7:0] tok_word = 8'h00;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    usbd_evt_status i_usbd_evt_status (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .tok_push(tok_push), .tok_word(tok_word), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [7:0] m_flags = 0, m_en = 0, m_clr;
    logic       m_tok = 0, m_tok_n, m_rearm = 0, m_ovf = 0, m_ack, m_drop;
    logic [7:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flags = 0; m_en = 0; m_tok = 0; m_rearm = 0; m_ovf = 0;
            m_q.delete();
        end else begin
            m_clr  = (reg_wr_en && reg_addr == 2'd0) ? reg_wdata : 8'h00;
            m_ack  = m_clr[3] && m_tok;
            m_drop = 1'b0;
            m_tok_n = m_tok;
            if (m_rearm) begin m_tok_n = 1'b1; m_rearm = 1'b0; end
            if (m_ack) begin
                m_q.delete(0);
                m_tok_n = 1'b0;
                if (m_q.size() > 0) m_rearm = 1'b1;
            end
            if (tok_push) begin
                if (m_q.size() < 2) begin
                    m_q.push_back(tok_word);
                    if (m_q.size() == 1) m_tok_n = 1'b1;
                end else m_drop = 1'b1;
            end
            m_tok   = m_tok_n;
            m_flags = ((m_flags & ~m_clr) | evt_pulse) & 8'hB7;
            if (reg_wr_en && reg_addr == 2'd1) m_en = reg_wdata & 8'hBF;
            m_ovf = (m_ovf && !(reg_wr_en && reg_addr == 2'd3 && reg_wdata[0])) || m_drop;
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_flags | {4'b0, m_tok, 3'b0};
            2'd1: return m_en;
            2'd2: return (m_q.size() > 0) ? m_q[0] : 8'h00;
            default: return {7'b0, m_ovf};
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: wait for the edge, compare against the model, drop strobes
    task automatic cycle();
        @(posedge clk);
        #1;
        check("model rdata", reg_rdata, m_read(reg_addr));
        check("model irq", {7'b0, irq_o}, {7'b0, |((m_flags | {4'b0, m_tok, 3'b0}) & m_en)});
        reg_wr_en = 1'b0; evt_pulse = 8'h00; tok_push = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
    endtask

    task automatic push(input logic [7:0] w);
        tok_push = 1'b1; tok_word = w;
        cycle();
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) cycle();
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(2'd0, 8'h00, "R1 flags");
        expect_rd(2'd1, 8'h00, "R1 enable");
        expect_rd(2'd2, 8'h00, "R1 token word");
        expect_rd(2'd3, 8'h00, "R1 overflow");
        check("R1 irq", {7'b0, irq_o}, 8'h00);

        // R2 all event lines; bits 6 and 3 ignored
        evt_pulse = 8'hFF; cycle();
        expect_rd(2'd0, 8'hB7, "R2 flags after pulses");

        // R3 write-1 clears, write-0 keeps
        wr(2'd0, 8'h05);
        expect_rd(2'd0, 8'hB2, "R3 partial clear");
        wr(2'd0, 8'h00);
        expect_rd(2'd0, 8'hB2, "R3 write zero");

        // R4 event beats clear
        evt_pulse = 8'h80; reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h80;
        cycle();
        expect_rd(2'd0, 8'hB2, "R4 event wins");
        wr(2'd0, 8'hFF);
        expect_rd(2'd0, 8'h00, "R3 clear all");

        // R5 enable mask and interrupt
        evt_pulse = 8'h02; cycle();
        check("R5 irq masked", {7'b0, irq_o}, 8'h00);
        wr(2'd1, 8'h02);
        check("R5 irq enabled", {7'b0, irq_o}, 8'h01);
        wr(2'd1, 8'hFF);
        expect_rd(2'd1, 8'hBF, "R5 enable readback");
        wr(2'd0, 8'h02);
        check("R5 irq after clear", {7'b0, irq_o}, 8'h00);
        wr(2'd1, 8'h00);

        // R6 first push
        push(8'h5A);
        expect_rd(2'd2, 8'h5A, "R6 word visible");
        expect_rd(2'd0, 8'h08, "R6 token flag");

        // R7 parked word promoted on acknowledge
        push(8'h3C);
        expect_rd(2'd2, 8'h5A, "R7 first word kept");
        wr(2'd0, 8'h08);
        expect_rd(2'd0, 8'h00, "R7 flag low during promote");
        expect_rd(2'd2, 8'h3C, "R7 promoted word");
        cycle();
        expect_rd(2'd0, 8'h08, "R7 flag returns");

        // R8 acknowledge with nothing parked
        wr(2'd0, 8'h08);
        expect_rd(2'd0, 8'h00, "R8 flag cleared");
        expect_rd(2'd2, 8'h00, "R8 word empty");

        // R9 overflow
        push(8'h11); push(8'h22); push(8'h33);
        expect_rd(2'd3, 8'h01, "R9 overflow set");
        expect_rd(2'd2, 8'h11, "R9 visible unchanged");
        wr(2'd3, 8'h01);
        expect_rd(2'd3, 8'h00, "R9 overflow cleared");

        // R11 push and acknowledge together with a parked word
        tok_push = 1'b1; tok_word = 8'h44;
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h22, "R11 parked promoted");
        cycle();
        expect_rd(2'd0, 8'h08, "R11 flag back");
        expect_rd(2'd3, 8'h00, "R11 no overflow");
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h44, "R11 pushed word followed");
        cycle();
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h00, "R8 drained");

        // R11 push and acknowledge together with nothing parked
        push(8'h66);
        tok_push = 1'b1; tok_word = 8'h77;
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h77, "R11 new word visible");
        expect_rd(2'd0, 8'h08, "R11 flag stays");
        wr(2'd0, 8'h08);

        // R10 acknowledge while flag low (re-arm cycle) is ignored
        push(8'h01); push(8'h02);
        wr(2'd0, 8'h08);
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h02, "R10 word kept");
        expect_rd(2'd0, 8'h08, "R10 flag set");
        wr(2'd0, 8'h08);
        expect_rd(2'd2, 8'h00, "R10 drained");

        repeat (4) cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule